// File: doc/BRIEF.md
# Three-Phase Dead-Time Shoot-Through Guard

This block sits between the filtered switch commands of a three-phase inverter and the gate drivers. Each phase, or leg, receives an upper-switch command and a lower-switch command. It produces two registered gate enables that are never both high. When one switch of a leg turns off, the opposite switch may turn on only after both enables have stayed low for a programmable number of clock cycles.

If the commanded gap between the two switches is already at least that long, the commands pass through unchanged, one cycle late. If the commanded gap is shorter, the turn-on is held back until the full dead time has elapsed. A leg that receives both commands at once keeps both switches off. A global force-off from the fault supervisor clears all six enables on the next cycle. After force-off is released, the same dead-time rule governs every turn-on.

Dead time is measured from the falling edge of the opposite gate enable. Each side of each leg has its own saturating timer, so the dead time is identical in both directions and on all three legs.

Top module: `bridge_deadtime_guard`

## Requirements
- R1: In every phase, `hi_gate[p]` and `lo_gate[p]` are never both 1 in the same cycle.
- R2: If a command rises less than DEAD_CYCLES cycles after the opposite gate fell, the output rises exactly when both gates of that phase have been low for DEAD_CYCLES consecutive cycles. This holds for high-to-low and for low-to-high transitions.
- R3: If a command rises DEAD_CYCLES or more cycles after the opposite gate fell, the output follows the command one cycle later, so the output gap equals the commanded gap.
- R4: While `hi_cmd[p]` and `lo_cmd[p]` are both 1, both gates of phase p are 0 from the next cycle on.
- R5: When a conflict clears, the command that is still high turns its gate on only after the opposite gate has been low for DEAD_CYCLES cycles.
- R6: `force_off`=1 drives all six gates to 0 in the next cycle, whatever the commands are.
- R7: After `force_off` is released, a gate turns on in the next cycle if its opposite gate has already been low for DEAD_CYCLES cycles; otherwise it waits until that holds.
- R8: A gate falls exactly one cycle after its command falls. Gates are registered, with a latency of one cycle.
- R9: The three phases act independently. A transition on one phase changes no gate of another phase.
- R10: While `rst_n`=0 all gates are 0. After reset, the dead time counts as already met, so the first command turns its gate on one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_off | input | 1 | Global shutdown from the fault supervisor; 1 turns all gates off |
| hi_cmd | input | NUM_PHASES | Filtered upper-switch command per phase (bit p = phase p) |
| lo_cmd | input | NUM_PHASES | Filtered lower-switch command per phase |
| hi_gate | output | NUM_PHASES | Registered upper-switch gate enable per phase |
| lo_gate | output | NUM_PHASES | Registered lower-switch gate enable per phase |

## Verification
Forced shutdown and the dead-time timer can meet in the same cycle. This happens when `force_off` clears gates whose opposite commands are waiting. The bench provokes it by forcing all legs off, then releasing the force while swapping every leg's command. No gate may turn on during the following DEAD_CYCLES-1 cycles, and all of them must turn on together in the cycle the forced fall has aged enough. The bench also releases the force while the opposite gates have long been off, and there it expects an immediate turn-on.

// File: rtl/bdg_pkg.sv
`timescale 1ns/1ps
package bdg_pkg;

   // Timer implementation variant chosen per instance.
   typedef enum logic {
      BDG_TIMER_UP   = 1'b0,
      BDG_TIMER_DOWN = 1'b1
   } bdg_timer_e;

   // Side indices within one leg.
   localparam int BDG_SIDE_HI = 0;
   localparam int BDG_SIDE_LO = 1;
   localparam int BDG_SIDES   = 2;

   // Counter width able to hold the value dead.
   function automatic int bdg_cnt_width(input int dead);
      return (dead < 2) ? 1 : $clog2(dead + 1);
   endfunction

endpackage

// File: rtl/bdg_gap_timer.sv
`timescale 1ns/1ps
// Measures how long the opposite gate of a leg has been low.
// gap_met is 1 when a turn-on at the next edge would leave both gates low
// for at least DEAD_CYCLES cycles.
module bdg_gap_timer
   import bdg_pkg::*;
#(
   parameter int         DEAD_CYCLES = 75,
   parameter bdg_timer_e STYLE       = BDG_TIMER_UP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic peer_on,
   output logic gap_met
);

   localparam int             CW       = bdg_cnt_width(DEAD_CYCLES);
   localparam logic [CW-1:0]  CNT_FULL = CW'(DEAD_CYCLES);
   localparam logic [CW-1:0]  CNT_LAST = CW'(DEAD_CYCLES - 1);

   if (DEAD_CYCLES < 1) begin : g_bad_dead
      $error("bdg_gap_timer: DEAD_CYCLES must be at least 1");
   end

   if (STYLE == BDG_TIMER_UP) begin : g_up
      // Counts low cycles of the peer, saturating at the full dead time.
      logic [CW-1:0] elapsed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            elapsed_q <= CNT_FULL;
         end else if (peer_on) begin
            elapsed_q <= '0;
         end else if (elapsed_q != CNT_FULL) begin
            elapsed_q <= elapsed_q + 1'b1;
         end
      end

      assign gap_met = !peer_on && (elapsed_q >= CNT_LAST);

      // R2: once saturated with the peer low, the count stays put
      a_r2_counter_saturates : assert property (@(posedge clk) disable iff (!rst_n)
         (elapsed_q == CNT_FULL && !peer_on) |=> (elapsed_q == CNT_FULL));
   end else begin : g_down
      // Loaded while the peer is on, then counts the remaining cycles down.
      logic [CW-1:0] remain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            remain_q <= '0;
         end else if (peer_on) begin
            remain_q <= CNT_LAST;
         end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
         end
      end

      assign gap_met = !peer_on && (remain_q == '0);

      // R2: an expired countdown stays expired while the peer is low
      a_r2_countdown_floor : assert property (@(posedge clk) disable iff (!rst_n)
         (remain_q == '0 && !peer_on) |=> (remain_q == '0));
   end

   if (DEAD_CYCLES > 1) begin : g_fall_check
      // R2: a peer that has only just fallen never permits a turn-on
      a_r2_fresh_fall_blocks : assert property (@(posedge clk) disable iff (!rst_n)
         $fell(peer_on) |-> !gap_met);
   end

endmodule

// File: rtl/bdg_leg.sv
`timescale 1ns/1ps
// One half-bridge leg: two registered gate enables guarded by dead time.
module bdg_leg
   import bdg_pkg::*;
#(
   parameter int         DEAD_CYCLES = 75,
   parameter bdg_timer_e STYLE       = BDG_TIMER_UP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic force_off,
   input  logic hi_cmd,
   input  logic lo_cmd,
   output logic hi_gate,
   output logic lo_gate
);

   logic [BDG_SIDES-1:0] cmd;
   logic [BDG_SIDES-1:0] met;
   logic [BDG_SIDES-1:0] gate_d;
   logic [BDG_SIDES-1:0] gate_q;

   assign cmd[BDG_SIDE_HI] = hi_cmd;
   assign cmd[BDG_SIDE_LO] = lo_cmd;

   for (genvar s = 0; s < BDG_SIDES; s++) begin : g_side
      localparam int PEER = BDG_SIDES - 1 - s;

      bdg_gap_timer #(
         .DEAD_CYCLES (DEAD_CYCLES),
         .STYLE       (STYLE)
      ) i_timer (
         .clk     (clk),
         .rst_n   (rst_n),
         .peer_on (gate_q[PEER]),
         .gap_met (met[s])
      );

      // A side turns on only with its own command alone and a met gap.
      assign gate_d[s] = !force_off && cmd[s] && !cmd[PEER] && met[s];

      // R2: a gate can rise only if its peer was already low before
      a_r2_rise_after_peer_low : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_q[s]) |-> $past(!gate_q[PEER]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q <= '0;
      end else begin
         gate_q <= gate_d;
      end
   end

   assign hi_gate = gate_q[BDG_SIDE_HI];
   assign lo_gate = gate_q[BDG_SIDE_LO];

   // R4: conflicting commands leave both gates off next cycle
   a_r4_conflict_both_off : assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cmd && lo_cmd) |=> (!hi_gate && !lo_gate));

   // R8: a dropped command clears its gate next cycle
   a_r8_turn_off_latency : assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_cmd) |=> !hi_gate);

endmodule

// File: rtl/bridge_deadtime_guard.sv
`timescale 1ns/1ps
// Three-phase (parameterised) dead-time and shoot-through guard.
module bridge_deadtime_guard
   import bdg_pkg::*;
#(
   parameter int         NUM_PHASES  = 3,
   parameter int         DEAD_CYCLES = 75,
   parameter bdg_timer_e TIMER_STYLE = BDG_TIMER_UP
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  force_off,
   input  logic [NUM_PHASES-1:0] hi_cmd,
   input  logic [NUM_PHASES-1:0] lo_cmd,
   output logic [NUM_PHASES-1:0] hi_gate,
   output logic [NUM_PHASES-1:0] lo_gate
);

   if (NUM_PHASES < 1) begin : g_bad_phases
      $error("bridge_deadtime_guard: NUM_PHASES must be at least 1");
   end
   if (DEAD_CYCLES < 1) begin : g_bad_dead
      $error("bridge_deadtime_guard: DEAD_CYCLES must be at least 1");
   end

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
      bdg_leg #(
         .DEAD_CYCLES (DEAD_CYCLES),
         .STYLE       (TIMER_STYLE)
      ) i_leg (
         .clk       (clk),
         .rst_n     (rst_n),
         .force_off (force_off),
         .hi_cmd    (hi_cmd[p]),
         .lo_cmd    (lo_cmd[p]),
         .hi_gate   (hi_gate[p]),
         .lo_gate   (lo_gate[p])
      );
   end

   // R1: no leg ever drives both switches
   a_r1_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      ((hi_gate & lo_gate) == '0));

   // R6: forced shutdown clears every gate one cycle later
   a_r6_force_clears_all : assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> ((hi_gate | lo_gate) == '0));

   // R10: the gates are low during reset
   always_comb begin
      if (!rst_n) begin
         a_r10_reset_low : assert ((hi_gate | lo_gate) == '0);
      end
   end

endmodule

// File: tb/test_bridge_deadtime_guard.sv
`timescale 1ns/1ps
module test_bridge_deadtime_guard;

   localparam int NP  = 3;
   localparam int BDT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          force_off = 1'b0;
   logic [NP-1:0] hi_cmd = '0;
   logic [NP-1:0] lo_cmd = '0;
   logic [NP-1:0] hi_gate;
   logic [NP-1:0] lo_gate;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   bridge_deadtime_guard #(
      .NUM_PHASES  (NP),
      .DEAD_CYCLES (BDT)
   ) i_bridge_deadtime_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_off (force_off),
      .hi_cmd    (hi_cmd),
      .lo_cmd    (lo_cmd),
      .hi_gate   (hi_gate),
      .lo_gate   (lo_gate)
   );

   typedef struct packed {
      logic       frc;
      logic [2:0] hi;
      logic [2:0] lo;
      logic [7:0] hold;
      logic [2:0] exp_hi;
      logic [2:0] exp_lo;
   } vec_t;

   localparam int NV = 23;
   // Expected values assume BDT = 6 dead cycles.
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'b001, 3'b000, 8'd1, 3'b001, 3'b000},  // R10 first turn-on
      '{1'b0, 3'b000, 3'b000, 8'd1, 3'b000, 3'b000},  // R8 turn-off
      '{1'b0, 3'b000, 3'b001, 8'd1, 3'b000, 3'b000},  // R2 gap 1 blocked
      '{1'b0, 3'b000, 3'b001, 8'd4, 3'b000, 3'b000},  // R2 still blocked at gap 5
      '{1'b0, 3'b000, 3'b001, 8'd1, 3'b000, 3'b001},  // R2 on at gap 6
      '{1'b0, 3'b000, 3'b000, 8'd1, 3'b000, 3'b000},  // R8 low turn-off
      '{1'b0, 3'b000, 3'b000, 8'd5, 3'b000, 3'b000},  // R3 idle gap
      '{1'b0, 3'b001, 3'b000, 8'd1, 3'b001, 3'b000},  // R3 long gap passes
      '{1'b0, 3'b001, 3'b001, 8'd1, 3'b000, 3'b000},  // R4 conflict
      '{1'b0, 3'b000, 3'b001, 8'd1, 3'b000, 3'b000},  // R5 blocked after conflict
      '{1'b0, 3'b000, 3'b001, 8'd4, 3'b000, 3'b000},  // R5 still blocked
      '{1'b0, 3'b000, 3'b001, 8'd1, 3'b000, 3'b001},  // R5 on
      '{1'b0, 3'b110, 3'b001, 8'd1, 3'b110, 3'b001},  // R9 other legs
      '{1'b1, 3'b110, 3'b001, 8'd1, 3'b000, 3'b000},  // R6 force
      '{1'b0, 3'b110, 3'b001, 8'd1, 3'b110, 3'b001},  // R7 release, gap met
      '{1'b0, 3'b100, 3'b011, 8'd1, 3'b100, 3'b001},  // R9 leg 1 swap only
      '{1'b0, 3'b100, 3'b011, 8'd5, 3'b100, 3'b001},  // R2 leg 1 waiting
      '{1'b0, 3'b100, 3'b011, 8'd1, 3'b100, 3'b011},  // R9 leg 1 on
      '{1'b1, 3'b100, 3'b011, 8'd1, 3'b000, 3'b000},  // R6 force again
      '{1'b0, 3'b011, 3'b100, 8'd1, 3'b000, 3'b000},  // R7 release with swap
      '{1'b0, 3'b011, 3'b100, 8'd4, 3'b000, 3'b000},  // R7 waiting
      '{1'b0, 3'b011, 3'b100, 8'd1, 3'b011, 3'b100},  // R7 all on together
      '{1'b0, 3'b000, 3'b000, 8'd1, 3'b000, 3'b000}   // R8 all off
   };
   localparam int VREQ [NV] = '{10, 8, 2, 2, 2, 8, 3, 3, 4, 5, 5, 5, 9,
                                6, 7, 9, 2, 9, 6, 7, 7, 7, 8};

   task automatic check_out(input int req, input logic [2:0] eh, input logic [2:0] el);
      checks++;
      if (hi_gate !== eh || lo_gate !== el) begin
         errors++;
         $display("FAIL R%0d: hi_gate=%b lo_gate=%b expected hi_gate=%b lo_gate=%b",
                  req, hi_gate, lo_gate, eh, el);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R10: gates stay low in reset even with commands high
      hi_cmd = 3'b111;
      step(3);
      check_out(10, 3'b000, 3'b000);
      hi_cmd = '0;
      rst_n  = 1'b1;

      for (int i = 0; i < NV; i++) begin
         force_off = VECS[i].frc;
         hi_cmd    = VECS[i].hi;
         lo_cmd    = VECS[i].lo;
         step(int'(VECS[i].hold));
         check_out(VREQ[i], VECS[i].exp_hi, VECS[i].exp_lo);
      end

      // R10: reset in operation clears the gates at once
      hi_cmd = 3'b111;
      lo_cmd = 3'b000;
      rst_n  = 1'b0;
      step(1);
      check_out(10, 3'b000, 3'b000);
      // R10: after reset the dead time counts as met
      rst_n = 1'b1;
      step(1);
      check_out(10, 3'b111, 3'b000);
      // R1: swapping all legs at once never overlaps
      hi_cmd = 3'b000;
      lo_cmd = 3'b111;
      step(1);
      check_out(1, 3'b000, 3'b000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule